// File: doc/BRIEF.md
# PWM Up/Down Time Base with Direction-Qualified Event Trigger

The block is a triangle-wave PWM time base with an event detector. While enabled, a counter climbs from zero to a programmable top value and then falls back to zero, without pausing. On every cycle the current count is compared with zero, with the top value and with two compare values, A and B. A match on a compare value is tagged with the direction of travel at that moment. Each compare value therefore yields two separate events, one rising and one falling. The zero and top events carry no direction.

Each of the six events has two enables in a 16-bit enable word. One enable routes the event into a single-cycle conversion-start pulse. The other sets a sticky raw interrupt status bit. Status bits are cleared by writing ones to a clear port. The block is meant to sit next to a PWM generator and time sampling of an ADC against the carrier.

Top module: `pwm_evt_unit`

## Requirements
- R1: After reset the trigger output is 0, all status bits are 0, and the counter stands at 0 with direction up.
- R2: While running with top value L>0, the count runs 0,1,…,L,L-1,…,1,0,1,… with a period of 2L cycles. Direction becomes down on the cycle the count reaches L and becomes up on the cycle it reaches 0.
- R3: With run low the count holds, no event occurs, and the trigger stays 0 from the next cycle on.
- R4: Event index 2 is compare A matched while up, and index 3 is compare A matched while down. Their trigger enables are bits 10 and 11, and their status enables are bits 2 and 3.
- R5: Event index 4 is compare B matched while up, and index 5 is compare B matched while down. Their trigger enables are bits 12 and 13, and their status enables are bits 4 and 5.
- R6: Event index 0 is count equals zero and index 1 is count equals top, neither direction-qualified. Their trigger enables are bits 8 and 9, and their status enables are bits 0 and 1.
- R7: The trigger is the OR of all trigger-enabled events. It appears one cycle after the count value that caused it and lasts one cycle per matching count value.
- R8: Status bit i is set when event i occurs with its status enable (bit i) set. It remains set until a 1 is written to clear bit i. An event in the same cycle as its clear leaves the bit set.
- R9: A compare value above the top value never matches. A compare value equal to the top value fires as a falling event together with the top event. A compare value of zero fires as a rising event together with the zero event.
- R10: Enable word bits 7:6 and 15:14 have no effect on the trigger or on the status.
- R11: With top value 0 the counter stays at 0, direction up, and the zero and top events occur on every running cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| runEn | input | 1 | Counter runs and events are detected while 1 |
| topVal | input | CNT_W | Top value of the triangle |
| cmpA | input | CNT_W | Compare value A |
| cmpB | input | CNT_W | Compare value B |
| evtEnable | input | 16 | Trigger enables in 13:8, status enables in 5:0 |
| stsClear | input | 6 | Write-one-to-clear for status bits |
| trigPulse | output | 1 | Single-cycle conversion-start pulse |
| rawSts | output | 6 | Sticky raw interrupt status, event order 0..5 |

## Verification
The bench builds the block with an 8-bit counter. This makes a full-scale top value of 255 reachable, together with compare values at 255 and 0, within a few hundred cycles. The same build also covers short triangles of one and five steps, a top value of zero, and compare values above the top. A behavioural model of the triangle and of the sticky status runs alongside, and both outputs are compared on every cycle as the enable patterns, clears and run gaps change.

// File: rtl/pwm_evt_pkg.sv
package pwm_evt_pkg;
  localparam int NUM_CMP  = 2;
  localparam int NUM_EV   = 2 + 2 * NUM_CMP;
  localparam int EN_W     = 16;
  localparam int TRIG_LSB = 8;
  localparam int EV_ZERO  = 0;
  localparam int EV_TOP   = 1;
  localparam int EV_CMP0  = 2;

  typedef struct packed {
    logic inc;
    logic dec;
    logic clr;
  } stepStrobe_t;

  typedef struct packed {
    logic isZero;
    logic isTop;
    logic aboveTop;
    logic nextIsTop;
    logic nextIsZero;
    logic topZero;
  } cntFlags_t;
endpackage

// File: rtl/pwm_evt_datapath.sv
module pwm_evt_datapath
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic [CNT_W-1:0]                topVal,
  input  logic [NUM_CMP-1:0][CNT_W-1:0]   cmpVals,
  input  stepStrobe_t                     stb,
  output cntFlags_t                       flags,
  output logic [NUM_CMP-1:0]              cmpHit
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] cntNext;
  logic [CNT_W:0]   cntPlus;

  always_comb begin
    cntNext = cnt;
    if (stb.clr)      cntNext = '0;
    else if (stb.inc) cntNext = cnt + CNT_W'(1);
    else if (stb.dec) cntNext = cnt - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) cnt <= '0;
    else       cnt <= cntNext;
  end

  assign cntPlus = {1'b0, cnt} + {{CNT_W{1'b0}}, 1'b1};

  always_comb begin
    flags.isZero     = (cnt == '0);
    flags.isTop      = (cnt == topVal);
    flags.aboveTop   = (cnt > topVal);
    flags.nextIsTop  = (cntPlus == {1'b0, topVal});
    flags.nextIsZero = (cnt == CNT_W'(1));
    flags.topZero    = (topVal == '0);
  end

  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    assign cmpHit[g] = (cnt == cmpVals[g]);
  end

  // R3: without a step strobe the count does not move
  p_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.inc && !stb.dec && !stb.clr) |=> $stable(cnt));

  // R2: an upward step never starts from the all-ones count
  p_no_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.inc |-> (cnt != '1));
endmodule

// File: rtl/pwm_evt_control.sv
module pwm_evt_control
  import pwm_evt_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  logic               runEn,
  input  logic [NUM_EV-1:0]  trigEn,
  input  logic [NUM_EV-1:0]  stsEn,
  input  logic [NUM_EV-1:0]  stsClear,
  input  cntFlags_t          flags,
  input  logic [NUM_CMP-1:0] cmpHit,
  output stepStrobe_t        stb,
  output logic               trigPulse,
  output logic [NUM_EV-1:0]  rawSts
);
  logic              dirUp;
  logic              dirNext;
  logic              goUp;
  logic [NUM_EV-1:0] evt;

  assign goUp = dirUp | flags.isZero;

  always_comb begin
    stb     = '0;
    dirNext = dirUp;
    if (runEn) begin
      if (flags.topZero) begin
        stb.clr = 1'b1;
        dirNext = 1'b1;
      end else if (goUp && !flags.isTop && !flags.aboveTop) begin
        stb.inc = 1'b1;
        dirNext = !flags.nextIsTop;
      end else begin
        stb.dec = 1'b1;
        dirNext = flags.nextIsZero;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) dirUp <= 1'b1;
    else       dirUp <= dirNext;
  end

  assign evt[EV_ZERO] = runEn & flags.isZero;
  assign evt[EV_TOP]  = runEn & flags.isTop;
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_dirSplit
    assign evt[EV_CMP0 + 2*g]     = runEn & cmpHit[g] & dirUp;
    assign evt[EV_CMP0 + 2*g + 1] = runEn & cmpHit[g] & ~dirUp;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      trigPulse <= 1'b0;
      rawSts    <= '0;
    end else begin
      trigPulse <= |(evt & trigEn);
      rawSts    <= (rawSts & ~stsClear) | (evt & stsEn);
    end
  end

  // R3: an idle cycle yields no pulse on the next cycle
  p_idle_notrig_r3: assert property (@(posedge clk) disable iff (!rstN)
    !runEn |=> !trigPulse);

  // R8: a status bit only drops after a clear was written to it
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(rawSts) & ~$past(stsClear)) & ~rawSts) == '0));

  // R2: reaching the top turns the direction down
  p_turn_down_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !flags.topZero && dirUp && !flags.isTop && !flags.aboveTop
     && flags.nextIsTop) |=> !dirUp);

  // R2: reaching zero turns the direction up
  p_turn_up_r2: assert property (@(posedge clk) disable iff (!rstN)
    (runEn && !flags.topZero && !dirUp && !flags.isZero && flags.nextIsZero)
    |=> dirUp);

  // R2: at most one step kind per cycle
  p_one_step_r2: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.inc, stb.dec, stb.clr}));
endmodule

// File: rtl/pwm_evt_unit.sv
module pwm_evt_unit
  import pwm_evt_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              runEn,
  input  logic [CNT_W-1:0]  topVal,
  input  logic [CNT_W-1:0]  cmpA,
  input  logic [CNT_W-1:0]  cmpB,
  input  logic [EN_W-1:0]   evtEnable,
  input  logic [NUM_EV-1:0] stsClear,
  output logic              trigPulse,
  output logic [NUM_EV-1:0] rawSts
);
  logic [NUM_CMP-1:0][CNT_W-1:0] cmpVals;
  logic [NUM_CMP-1:0]            cmpHit;
  stepStrobe_t                   stb;
  cntFlags_t                     flags;
  logic                          unusedEnBits;

  assign cmpVals[0] = cmpA;
  assign cmpVals[1] = cmpB;
  // R10: spare enable bits feed nothing
  assign unusedEnBits = ^{evtEnable[15:14], evtEnable[7:6]};

  pwm_evt_datapath #(.CNT_W(CNT_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .topVal  (topVal),
    .cmpVals (cmpVals),
    .stb     (stb),
    .flags   (flags),
    .cmpHit  (cmpHit)
  );

  pwm_evt_control u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .runEn     (runEn),
    .trigEn    (evtEnable[TRIG_LSB +: NUM_EV]),
    .stsEn     (evtEnable[0 +: NUM_EV]),
    .stsClear  (stsClear),
    .flags     (flags),
    .cmpHit    (cmpHit),
    .stb       (stb),
    .trigPulse (trigPulse),
    .rawSts    (rawSts)
  );
endmodule

// File: tb/pwm_evt_unit_bench.sv
module pwm_evt_unit_bench;
  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         runEn = 1'b0;
  logic [W-1:0] topVal = '0;
  logic [W-1:0] cmpA = '0;
  logic [W-1:0] cmpB = '0;
  logic [15:0]  evtEnable = '0;
  logic [5:0]   stsClear = '0;
  logic         trigPulse;
  logic [5:0]   rawSts;

  int    nChecks = 0;
  int    nFails  = 0;
  string phase   = "R1";
  bit    cmpOn   = 1'b0;

  int       mCnt;
  bit       mUp;
  bit       expTrig;
  bit [5:0] expSts;

  always #10 clk = ~clk;

  pwm_evt_unit #(.CNT_W(W)) u_pwm_evt_unit (
    .clk(clk), .rstN(rstN), .runEn(runEn), .topVal(topVal), .cmpA(cmpA),
    .cmpB(cmpB), .evtEnable(evtEnable), .stsClear(stsClear),
    .trigPulse(trigPulse), .rawSts(rawSts)
  );

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: triangle walk and sticky status
  always @(posedge clk) begin
    if (!rstN) begin
      mCnt = 0; mUp = 1; expTrig = 0; expSts = '0;
    end else begin
      bit [5:0] ev;
      ev[0] = runEn && (mCnt == 0);
      ev[1] = runEn && (mCnt == int'(topVal));
      ev[2] = runEn && (mCnt == int'(cmpA)) && mUp;
      ev[3] = runEn && (mCnt == int'(cmpA)) && !mUp;
      ev[4] = runEn && (mCnt == int'(cmpB)) && mUp;
      ev[5] = runEn && (mCnt == int'(cmpB)) && !mUp;
      expTrig = |(ev & evtEnable[13:8]);
      expSts  = (expSts & ~stsClear) | (ev & evtEnable[5:0]);
      if (runEn) begin
        if (topVal == 0) begin
          mCnt = 0; mUp = 1;
        end else if ((mUp || mCnt == 0) && mCnt < int'(topVal)) begin
          mCnt++;
          mUp = (mCnt != int'(topVal));
        end else begin
          mCnt--;
          mUp = (mCnt == 0);
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rstN && cmpOn) begin
      check({phase, " trig"}, int'(trigPulse), int'(expTrig));
      check({phase, " sts"}, int'(rawSts), int'(expSts));
    end
  end

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic clearAll();
    @(negedge clk); stsClear = 6'h3f;
    @(negedge clk); stsClear = 6'h00;
  endtask

  initial begin
    #2000000;
    nFails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    cycles(3);
    rstN = 1'b1;
    @(negedge clk);
    // R1: reset state at the ports
    check("R1 trig", int'(trigPulse), 0);
    check("R1 sts", int'(rawSts), 0);
    cmpOn = 1'b1;

    // R2 R6 R7: top 5, zero and top events
    phase = "R2"; topVal = 5; cmpA = 2; cmpB = 4;
    evtEnable = 16'h0303; runEn = 1'b1;
    cycles(25);
    phase = "R6"; clearAll(); cycles(12);

    // R4: compare A split by direction
    phase = "R4"; evtEnable = 16'h040C; clearAll(); cycles(12);
    evtEnable = 16'h0804; clearAll(); cycles(12);

    // R5: compare B split by direction
    phase = "R5"; evtEnable = 16'h1030; clearAll(); cycles(12);
    evtEnable = 16'h2010; clearAll(); cycles(12);

    // R7: OR of several enabled events
    phase = "R7"; evtEnable = 16'h3F00; cycles(14);

    // R10: only spare bits set
    phase = "R10"; evtEnable = 16'hC0C0; clearAll(); cycles(15);
    check("R10 sts idle", int'(rawSts), 0);

    // R9: compare above top, equal to top, equal to zero
    phase = "R9"; evtEnable = 16'h3F3F; cmpA = 9; cmpB = 5;
    clearAll(); cycles(14);
    cmpA = 0; cmpB = 200; clearAll(); cycles(14);

    // R8: clear while event recurs, set wins
    phase = "R8"; topVal = 1; cmpA = 1; cmpB = 0; evtEnable = 16'h003F;
    stsClear = 6'h3f; cycles(6); stsClear = 6'h00; cycles(4);
    runEn = 1'b0; cycles(2); stsClear = 6'h0A; cycles(1); stsClear = 6'h00;
    cycles(3);

    // R3: idle holds count and suppresses events
    phase = "R3"; evtEnable = 16'h3F3F; topVal = 6; cmpA = 3;
    clearAll(); cycles(10); runEn = 1'b1; cycles(5);
    runEn = 1'b0; cycles(8); runEn = 1'b1; cycles(16);

    // R11: top value zero
    phase = "R11"; topVal = 0; clearAll(); cycles(12);

    // R2 full-scale triangle
    phase = "R2"; topVal = 8'hFF; cmpA = 8'hFF; cmpB = 0;
    evtEnable = 16'h3A3F; clearAll(); cycles(560);

    cmpOn = 1'b0;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end
endmodule